// File: doc/BRIEF.md
# R-Peak Detector with Heart-Rate Output

This block watches a stream of QRS-feature samples, such as the output of a band-pass, slope and smoothing front end, and finds R peaks. A sample is accepted as a peak when it is strictly larger than a programmable threshold and strictly larger than every one of the eight samples that come after it. The decision can only be made once those eight later samples have arrived, so every beat is reported eight samples after the peak itself.

Between accepted peaks the block counts accepted samples to form the beat-to-beat interval. At a 200 Hz sample rate, beats per minute is 12000 divided by that interval in samples. A sequential divider works out this quotient one bit per clock. The first peak after reset only arms the interval counter. An interval too long for the counter is flagged as an overflow, and no rate is produced for that beat.

Top module: `rpeak_rate_detector`

## Requirements
- R1: A sample is a peak only if it is strictly greater than the threshold and strictly greater than each of the next eight valid samples. Equal values (a flat top, or a value equal to the threshold) do not qualify, so a plateau yields at most one peak.
- R2: `beat` is a one-cycle-wide registered strobe. It is high in the cycle after the `in_valid` cycle that delivered the eighth later sample of the peak.
- R3: The threshold register holds 8000 after reset. A cycle with `thr_we` high loads `thr_wdata`, and the new value governs every decision after that cycle.
- R4: `interval` holds the number of valid samples from the previous peak to the current one. It is updated only together with a beat that starts a rate computation, and it is held otherwise.
- R5: `rate` becomes floor(12000 / interval). It is updated, and `rate_valid` pulses for one cycle, 14 cycles after the beat that started the division. `rate` is held otherwise.
- R6: `rate_busy` is high from the beat that starts a division until the result cycle. A new rated beat during a division, including in its result cycle, restarts it with the new interval, and no result is given for the abandoned division.
- R7: The first peak after reset raises `beat`, but leaves `interval` at 0 and starts no division.
- R8: The interval counter saturates at 65535. A peak found while it is saturated pulses `overflow` together with `beat`, leaves `interval` and the divider untouched, and restarts the count.
- R9: Samples presented with `in_valid` low are ignored. They neither enter the lookahead window nor advance the interval count.
- R10: After reset `beat`, `overflow`, `rate_valid` and `rate_busy` are low, and `interval` and `rate` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new feature sample is present |
| in_sample | input | 16 | Unsigned feature sample |
| thr_we | input | 1 | Load the threshold register |
| thr_wdata | input | 16 | New threshold value |
| beat | output | 1 | One-cycle strobe per accepted peak |
| interval | output | 16 | Last peak-to-peak interval in samples |
| overflow | output | 1 | Beat arrived with the interval counter saturated |
| rate | output | 14 | Heart rate in beats per minute |
| rate_valid | output | 1 | One-cycle strobe when `rate` updates |
| rate_busy | output | 1 | Divider is computing |

## Verification
The collision that matters is between a new rated beat and the divider's last step, or any step while it is busy. Both can land on the same clock edge. The bench provokes this with peak trains spaced exactly 14 samples apart, which puts a start in the result cycle of the previous division, and with peaks only 5 samples apart, which restart a division in the middle. A behavioural reference model written with sample queues and integer division is compared with the outputs on every clock. It expects the start to win: `rate_busy` stays high, `rate_valid` does not pulse and `rate` keeps its old value until the last division completes.

// File: rtl/rpk_pkg.sv
package rpk_pkg;

    // Phase of the sequential rate divider.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_phase_e;

    // Kind of event produced by a peak decision.
    typedef struct packed {
        logic hit;    // a peak was accepted
        logic rated;  // the peak starts a rate computation
    } beat_kind_t;

    // Width needed for the beats-per-minute quotient (60 * sample rate).
    function automatic int rate_width(input int hz);
        return $clog2(60 * hz + 1);
    endfunction

    // Width of a down-counter that must hold the value n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rpk_window.sv
module rpk_window #(
    parameter int SW   = 16,
    parameter int LOOK = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sample,
    input  logic [SW-1:0] thr,
    output logic          peak
);
    localparam int FW = rpk_pkg::count_width(LOOK);
    localparam logic [FW-1:0] FULL = FW'(LOOK);

    // hold[0] is the newest stored sample, hold[LOOK-1] the candidate.
    logic [SW-1:0] hold [LOOK];
    logic [FW-1:0] fill;
    logic [LOOK-1:0] wins;
    logic [SW-1:0] cand;

    assign cand = hold[LOOK-1];

    // One strict comparator per later sample; the newest later sample
    // is the one arriving this cycle.
    for (genvar k = 0; k < LOOK; k++) begin : g_cmp
        if (k == LOOK - 1) begin : g_in
            assign wins[k] = cand > in_sample;
        end else begin : g_hold
            assign wins[k] = cand > hold[k];
        end
    end

    assign peak = in_valid && (fill == FULL) && (cand > thr) && (&wins);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
            for (int k = 0; k < LOOK; k++) hold[k] <= '0;
        end else if (in_valid) begin
            hold[0] <= in_sample;
            for (int k = 1; k < LOOK; k++) hold[k] <= hold[k-1];
            if (fill != FULL) fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/rpk_interval.sv
module rpk_interval #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          peak,
    output logic          start,
    output logic [CW-1:0] interval,
    output logic          ovf
);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;
    logic          armed;
    logic          sat;

    assign sat   = (cnt == CMAX);
    assign start = step && peak && armed && !sat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            interval <= '0;
            ovf      <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (step) begin
                if (peak) begin
                    armed <= 1'b1;
                    cnt   <= ONE;
                    if (armed) begin
                        if (sat) ovf <= 1'b1;
                        else     interval <= cnt;
                    end
                end else if (armed && !sat) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rpk_rate_div.sv
module rpk_rate_div #(
    parameter int CW  = 16,
    parameter int NUM = 12000,
    parameter int QW  = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [QW-1:0] quotient
);
    import rpk_pkg::*;

    localparam int LW = count_width(QW);
    localparam logic [QW-1:0] DIVIDEND = QW'(NUM);
    localparam logic [LW-1:0] STEPS    = LW'(QW);
    localparam logic [LW-1:0] LAST     = LW'(1);

    div_phase_e    phase;
    logic [LW-1:0] left;
    logic [CW-1:0] rem;
    logic [QW-1:0] quo;
    logic [CW-1:0] dsr;

    logic [CW:0]   rem_sh;
    logic          fits;
    logic [CW-1:0] rem_nx;
    logic [QW-1:0] quo_nx;

    // One restoring-division step per clock.
    always_comb begin
        rem_sh = {rem, quo[QW-1]};
        fits   = rem_sh >= {1'b0, dsr};
        rem_nx = fits ? CW'(rem_sh - {1'b0, dsr}) : CW'(rem_sh);
        quo_nx = {quo[QW-2:0], fits};
    end

    assign busy = (phase == DIV_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= DIV_IDLE;
            left     <= '0;
            rem      <= '0;
            quo      <= '0;
            dsr      <= '0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= DIV_RUN;
                left  <= STEPS;
                rem   <= '0;
                quo   <= DIVIDEND;
                dsr   <= divisor;
            end else if (phase == DIV_RUN) begin
                rem  <= rem_nx;
                quo  <= quo_nx;
                left <= left - 1'b1;
                if (left == LAST) begin
                    phase    <= DIV_IDLE;
                    quotient <= quo_nx;
                    done     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rpeak_rate_detector.sv
module rpeak_rate_detector #(
    parameter int SAMPLE_W  = 16,
    parameter int LOOKAHEAD = 8,
    parameter int THR_RESET = 8000,
    parameter int SAMPLE_HZ = 200,
    parameter int CNT_W     = 16,
    parameter int RATE_W    = rpk_pkg::rate_width(SAMPLE_HZ)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                thr_we,
    input  logic [SAMPLE_W-1:0] thr_wdata,
    output logic                beat,
    output logic [CNT_W-1:0]    interval,
    output logic                overflow,
    output logic [RATE_W-1:0]   rate,
    output logic                rate_valid,
    output logic                rate_busy
);
    import rpk_pkg::*;

    localparam int BPM_NUM = 60 * SAMPLE_HZ;
    localparam logic [SAMPLE_W-1:0] THR_INIT = SAMPLE_W'(THR_RESET);

    logic [SAMPLE_W-1:0] thr;
    logic                peak;
    beat_kind_t          kind;

    always_ff @(posedge clk) begin
        if (rst)         thr <= THR_INIT;
        else if (thr_we) thr <= thr_wdata;
    end

    rpk_window #(
        .SW   (SAMPLE_W),
        .LOOK (LOOKAHEAD)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .thr       (thr),
        .peak      (peak)
    );

    rpk_interval #(
        .CW (CNT_W)
    ) u_interval (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .peak     (peak),
        .start    (kind.rated),
        .interval (interval),
        .ovf      (overflow)
    );

    assign kind.hit = peak;

    always_ff @(posedge clk) begin
        if (rst) beat <= 1'b0;
        else     beat <= kind.hit;
    end

    rpk_rate_div #(
        .CW  (CNT_W),
        .NUM (BPM_NUM),
        .QW  (RATE_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (kind.rated),
        .divisor  (interval_next(kind.rated)),
        .busy     (rate_busy),
        .done     (rate_valid),
        .quotient (rate)
    );

    // The divisor is the count that the interval register captures on
    // the same edge as the start.
    function automatic logic [CNT_W-1:0] interval_next(input logic go);
        return go ? u_interval.cnt : interval;
    endfunction
endmodule

// File: rtl/rpk_checker.sv
module rpk_checker #(
    parameter int CNT_W  = 16,
    parameter int RATE_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              beat,
    input logic [CNT_W-1:0]  interval,
    input logic              overflow,
    input logic [RATE_W-1:0] rate,
    input logic              rate_valid,
    input logic              rate_busy
);
    // R2: a beat only follows a cycle that delivered a sample
    p_beat_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
        beat |-> $past(in_valid));

    // R4: the interval only moves together with a beat
    p_interval_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !beat |-> $stable(interval));

    // R5: the rate only moves with its valid strobe
    p_rate_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !rate_valid |-> $stable(rate));

    // R5: a result ends a busy period
    p_done_from_busy_r5: assert property (@(posedge clk) disable iff (rst)
        rate_valid |-> ($past(rate_busy) && !rate_busy));

    // R6: busy ends only through a result
    p_busy_ends_r6: assert property (@(posedge clk) disable iff (rst)
        rate_busy |=> (rate_busy || rate_valid));

    // R8: overflow is reported only alongside a beat
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |-> beat);
endmodule

bind rpeak_rate_detector rpk_checker #(
    .CNT_W  (CNT_W),
    .RATE_W (RATE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .beat       (beat),
    .interval   (interval),
    .overflow   (overflow),
    .rate       (rate),
    .rate_valid (rate_valid),
    .rate_busy  (rate_busy)
);

// File: tb/rpeak_rate_detector_test.sv
module rpeak_rate_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOOK  = 8;
    localparam int NUM   = 12000;
    localparam int STEPS = $clog2(NUM + 1);
    localparam int SATV  = 65535;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        thr_we = 1'b0;
    logic [15:0] thr_wdata = '0;
    logic        beat;
    logic [15:0] interval;
    logic        overflow;
    logic [13:0] rate;
    logic        rate_valid;
    logic        rate_busy;

    rpeak_rate_detector uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .thr_we     (thr_we),
        .thr_wdata  (thr_wdata),
        .beat       (beat),
        .interval   (interval),
        .overflow   (overflow),
        .rate       (rate),
        .rate_valid (rate_valid),
        .rate_busy  (rate_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int nbeats = 0;
    int novf = 0;
    int gap_max = 0;
    bit compare_on = 1'b0;

    task automatic check(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int q[$];
    int m_thr, m_idx, m_last, m_int, m_rate, m_steps, m_pend;
    bit m_armed, m_beat, m_ovf, m_rv, m_busy;

    always @(posedge clk) begin
        int thr_now;
        bit pk, go;
        int d;
        if (rst) begin
            q.delete();
            m_thr = 8000; m_idx = 0; m_last = 0; m_int = 0; m_rate = 0;
            m_steps = 0; m_pend = 0; m_armed = 0; m_beat = 0; m_ovf = 0;
            m_rv = 0; m_busy = 0;
        end else begin
            thr_now = m_thr;
            m_beat = 0; m_ovf = 0; m_rv = 0; go = 0;
            if (in_valid) begin
                q.push_back(int'(in_sample));
                m_idx++;
                if (q.size() == LOOK + 1) begin
                    pk = q[0] > thr_now;
                    for (int j = 1; j <= LOOK; j++) if (q[j] >= q[0]) pk = 0;
                    q.pop_front();
                    if (pk) begin
                        m_beat = 1;
                        if (m_armed) begin
                            d = m_idx - m_last;
                            if (d >= SATV) m_ovf = 1;
                            else begin
                                m_int = d; go = 1; m_pend = NUM / d;
                            end
                        end
                        m_armed = 1;
                        m_last = m_idx;
                    end
                end
            end
            if (go) begin
                m_busy = 1; m_steps = STEPS;
            end else if (m_busy) begin
                m_steps--;
                if (m_steps == 0) begin
                    m_busy = 0; m_rate = m_pend; m_rv = 1;
                end
            end
            if (thr_we) m_thr = int'(thr_wdata);
        end
    end

    // Outputs compared away from the active edge.
    always @(negedge clk) begin
        if (!rst && compare_on) begin
            check("R2 beat", beat, m_beat);
            check("R4 interval", interval, m_int);
            check("R8 overflow", overflow, m_ovf);
            check("R5 rate_valid", rate_valid, m_rv);
            check("R5 rate", rate, m_rate);
            check("R6 rate_busy", rate_busy, m_busy);
            if (beat) nbeats++;
            if (overflow) novf++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(input int s);
        int g;
        g = (gap_max > 0) ? $urandom_range(gap_max, 0) : 0;
        repeat (g) begin
            @(negedge clk); in_valid = 1'b0; in_sample = 16'hFFFF;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'(s);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); in_valid = 1'b0; in_sample = 16'hFFFF; thr_we = 1'b0;
        end
    endtask

    task automatic set_thr(input int v);
        @(negedge clk);
        in_valid = 1'b0; thr_we = 1'b1; thr_wdata = 16'(v);
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic train(input int h, input int spacing, input int count);
        for (int i = 0; i < count; i++) begin
            put(h);
            repeat (spacing - 1) put(0);
        end
        idle(24);
    endtask

    int b0, o0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 beat", beat, 0);
        check("R10 interval", interval, 0);
        check("R10 rate", rate, 0);
        check("R10 rate_busy", rate_busy, 0);
        check("R10 rate_valid", rate_valid, 0);
        compare_on = 1'b1;

        // R7: first peak only arms the counter
        put(20000);
        repeat (LOOK) put(0);
        idle(3);
        check("R7 beats", nbeats, 1);
        check("R7 interval", interval, 0);
        check("R7 rate_busy", rate_busy, 0);

        // R4/R5: regular train at 75 bpm
        train(20000, 160, 4);
        check("R4 interval", interval, 160);
        check("R5 rate", rate, 75);

        // R1: flat top gives one peak, equal-to-threshold gives none
        b0 = nbeats;
        put(21000); put(21000);
        repeat (LOOK + 2) put(0);
        idle(4);
        check("R1 plateau beats", nbeats - b0, 1);
        b0 = nbeats;
        put(8000);
        repeat (LOOK + 2) put(0);
        idle(4);
        check("R1 at-threshold beats", nbeats - b0, 0);
        b0 = nbeats;
        put(8001);
        repeat (LOOK + 2) put(0);
        idle(24);
        check("R1 above-threshold beats", nbeats - b0, 1);

        // R3: programmable threshold
        set_thr(25000);
        b0 = nbeats;
        train(20000, 50, 3);
        check("R3 high threshold beats", nbeats - b0, 0);
        set_thr(1000);
        b0 = nbeats;
        train(3000, 40, 3);
        check("R3 low threshold beats", nbeats - b0, 3);
        set_thr(8000);

        // R9: gaps with junk on the bus are ignored
        gap_max = 3;
        train(20000, 100, 4);
        gap_max = 0;
        check("R9 interval", interval, 100);
        check("R9 rate", rate, 120);

        // R6: restart mid-division and in the result cycle
        put(30000); repeat (4) put(0);
        put(29000); repeat (4) put(0);
        put(28000); repeat (10) put(0);
        idle(4);
        train(20000, 14, 4);
        check("R6 interval", interval, 14);
        check("R6 rate", rate, NUM / 14);

        // R8: saturation of the interval counter
        o0 = novf;
        put(20000);
        repeat (65600) put(0);
        put(20000);
        repeat (LOOK + 2) put(0);
        idle(20);
        check("R8 overflow count", novf - o0, 1);
        check("R8 interval held", interval, 14);
        idle(2);
        b0 = nbeats;
        repeat (89) put(0);
        put(20000);
        repeat (LOOK + 2) put(0);
        idle(24);
        check("R8 recovered beats", nbeats - b0, 1);
        check("R8 recovered interval", interval, 100);
        check("R8 recovered rate", rate, 120);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule